// File: doc/BRIEF.md
# Banked modem-control register block

This block is the register file and address decoder that sits behind a UART's host bus for the modem-control group. A host reaches it through a 3-bit offset with separate write and read strobes and 8-bit data. It holds the modem control word, a scratch byte, a trigger-control byte, a trigger-level byte and an enhanced-feature byte. The modem status byte is not stored here. It arrives on an input, and the block places it on the read path.

Offsets 6 and 7 are banked. Each offset reaches one of two registers, and which one depends on the enhanced-feature enable together with one control bit. The same enable guards two control bits against writes. The block also produces the modem signals used in internal loopback. These are a ring indicator driven from a control bit and an inverted auxiliary output. While loopback is on, these signals replace the upper status bits seen by the host. Write data is captured on the rising clock edge. Read data is combinational while the read strobe is high.

Top module: `uart_modem_regs`

## Requirements
- R1: At offset 6, an access reaches the trigger-control register only when enhanced-feature bit 4 and control bit 2 are both 1. In every other case it reaches the modem status location.
- R2: At offset 7, an access reaches the trigger-level register only when enhanced-feature bit 4 and control bit 2 are both 1. Otherwise it reaches the scratch register.
- R3: Control bits 5 and 6 take write data only while enhanced-feature bit 4 is 1. At other times a write to offset 4 leaves them unchanged.
- R4: A write to the modem status location changes no register. A read of it returns `modem_stat_in`.
- R5: While control bit 4 (loopback) is 1, a status read returns control bits {3,2,0,1} in status bits [7:4], with bits [3:0] taken from `modem_stat_in`.
- R6: `lb_ri_o` equals control bit 2 while loopback is on, and is 0 otherwise.
- R7: `op2_o` is the inverse of control bit 3 while loopback is on, and is 1 otherwise.
- R8: Synchronous active-high reset clears every register. All register outputs then read 0 and `op2_o` reads 1.
- R9: The enhanced-feature register is written and read at offset 2 only while `enh_sel` is 1. Without it, offset 2 writes are ignored and read 0. Offsets 0, 1, 3 and 5 read 0, and `reg_rdata` is 0 whenever `reg_rd` is 0.
- R10: Offset 4 reads back the control byte, and its unprotected bits are always writable. `loop_en_o`, `xon_any_o` and `ir_en_o` follow control bits 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_offset | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| enh_sel | input | 1 | Selects the enhanced-feature register at offset 2 |
| modem_stat_in | input | 8 | Modem status byte from the status logic |
| reg_rdata | output | 8 | Read data |
| mcr_q_o | output | 8 | Control byte |
| tcr_o | output | 8 | Trigger-control byte |
| tlr_o | output | 8 | Trigger-level byte |
| enh_en_o | output | 1 | Enhanced-feature enable (bit 4) |
| loop_en_o | output | 1 | Loopback enable |
| xon_any_o | output | 1 | Resume-on-any-character enable |
| ir_en_o | output | 1 | Infrared mode enable |
| lb_ri_o | output | 1 | Internal ring indicator |
| op2_o | output | 1 | Internal auxiliary output 2, active low |

## Verification
The assertions check the following on every cycle: the banked trigger writes and reads, that status-location writes leave state alone, that the guarded bits hold on unenabled writes, the loopback output relations, the values after reset, and the idle read data. The loopback substitution in status reads is checked by the bench, as are offset-2 selection and the full history of mixed, randomly interleaved writes. Those checks compare against a bench reference model over a seeded random run with directed corner cases.

// File: rtl/umr_pkg.sv
package umr_pkg;
   // control byte bit positions (behavioural, decoded by neighbours)
   localparam int MCR_DTR  = 0;
   localparam int MCR_RTS  = 1;
   localparam int MCR_BANK = 2;
   localparam int MCR_OP2  = 3;
   localparam int MCR_LOOP = 4;
   localparam int MCR_XON  = 5;
   localparam int MCR_IR   = 6;

   typedef struct packed {
      logic efr;
      logic mcr;
      logic msr;
      logic tcr;
      logic spr;
      logic tlr;
   } umr_sel_t;
endpackage

// File: rtl/umr_addr_decode.sv
module umr_addr_decode
   import umr_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int OFF_EFR  = 2,
   parameter int OFF_MCR  = 4,
   parameter int OFF_BNKA = 6,
   parameter int OFF_BNKB = 7
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic              enh_sel,
   input  logic              bank_alt,
   output umr_sel_t          sel
);
   always_comb begin
      sel.efr = (offset == ADDR_W'(OFF_EFR)) && enh_sel;
      sel.mcr = (offset == ADDR_W'(OFF_MCR));
      sel.msr = (offset == ADDR_W'(OFF_BNKA)) && !bank_alt;
      sel.tcr = (offset == ADDR_W'(OFF_BNKA)) &&  bank_alt;
      sel.spr = (offset == ADDR_W'(OFF_BNKB)) && !bank_alt;
      sel.tlr = (offset == ADDR_W'(OFF_BNKB)) &&  bank_alt;
   end
endmodule

// File: rtl/umr_ctl_reg.sv
module umr_ctl_reg #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] PROT_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic              unlock,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic bit_we;
      if (PROT_MASK[i]) begin : g_guarded
         assign bit_we = we && unlock;
      end else begin : g_open
         assign bit_we = we;
      end
      always_ff @(posedge clk) begin
         if (rst)         q[i] <= 1'b0;
         else if (bit_we) q[i] <= wdata[i];
      end
   end
endmodule

// File: rtl/umr_read_mux.sv
module umr_read_mux
   import umr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rd,
   input  umr_sel_t          sel,
   input  logic [DATA_W-1:0] efr,
   input  logic [DATA_W-1:0] mcr,
   input  logic [DATA_W-1:0] msr,
   input  logic [DATA_W-1:0] tcr,
   input  logic [DATA_W-1:0] spr,
   input  logic [DATA_W-1:0] tlr,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd) begin
         rdata = ({DATA_W{sel.efr}} & efr) | ({DATA_W{sel.mcr}} & mcr)
               | ({DATA_W{sel.msr}} & msr) | ({DATA_W{sel.tcr}} & tcr)
               | ({DATA_W{sel.spr}} & spr) | ({DATA_W{sel.tlr}} & tlr);
      end
   end
endmodule

// File: rtl/uart_modem_regs.sv
module uart_modem_regs
   import umr_pkg::*;
#(
   parameter int                ADDR_W    = 3,
   parameter int                DATA_W    = 8,
   parameter int                ENH_BIT   = 4,
   parameter int                OFF_EFR   = 2,
   parameter int                OFF_MCR   = 4,
   parameter int                OFF_BNKA  = 6,
   parameter int                OFF_BNKB  = 7,
   parameter logic [DATA_W-1:0] PROT_MASK = DATA_W'(8'h60)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] reg_offset,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              enh_sel,
   input  logic [DATA_W-1:0] modem_stat_in,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] mcr_q_o,
   output logic [DATA_W-1:0] tcr_o,
   output logic [DATA_W-1:0] tlr_o,
   output logic              enh_en_o,
   output logic              loop_en_o,
   output logic              xon_any_o,
   output logic              ir_en_o,
   output logic              lb_ri_o,
   output logic              op2_o
);
   localparam int NUM_OFF = 1 << ADDR_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (ENH_BIT >= DATA_W) begin : g_bad_enh
      $error("ENH_BIT outside data width");
   end
   if (OFF_EFR >= NUM_OFF || OFF_MCR >= NUM_OFF || OFF_BNKA >= NUM_OFF || OFF_BNKB >= NUM_OFF) begin : g_bad_off
      $error("offset outside address range");
   end
   if (OFF_EFR == OFF_MCR || OFF_BNKA == OFF_BNKB || OFF_MCR == OFF_BNKA
       || OFF_MCR == OFF_BNKB || OFF_EFR == OFF_BNKA || OFF_EFR == OFF_BNKB) begin : g_bad_alias
      $error("register offsets must be distinct");
   end

   logic [DATA_W-1:0] efr_q, mcr_q, tcr_q, spr_q, tlr_q, msr_view;
   logic              bank_alt, loop_on;
   umr_sel_t          sel;

   assign bank_alt = efr_q[ENH_BIT] && mcr_q[MCR_BANK];
   assign loop_on  = mcr_q[MCR_LOOP];

   umr_addr_decode #(
      .ADDR_W(ADDR_W), .OFF_EFR(OFF_EFR), .OFF_MCR(OFF_MCR),
      .OFF_BNKA(OFF_BNKA), .OFF_BNKB(OFF_BNKB)
   ) u_dec (
      .offset(reg_offset), .enh_sel(enh_sel), .bank_alt(bank_alt), .sel(sel)
   );

   umr_ctl_reg #(.DATA_W(DATA_W), .PROT_MASK(PROT_MASK)) u_mcr (
      .clk(clk), .rst(rst), .we(reg_wr && sel.mcr),
      .unlock(efr_q[ENH_BIT]), .wdata(reg_wdata), .q(mcr_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         efr_q <= '0;
         tcr_q <= '0;
         spr_q <= '0;
         tlr_q <= '0;
      end else if (reg_wr) begin
         if (sel.efr) efr_q <= reg_wdata;
         if (sel.tcr) tcr_q <= reg_wdata;
         if (sel.spr) spr_q <= reg_wdata;
         if (sel.tlr) tlr_q <= reg_wdata;
      end
   end

   // loopback replaces the upper status bits with looped control bits
   always_comb begin
      msr_view = modem_stat_in;
      if (loop_on) begin
         msr_view[7] = mcr_q[MCR_OP2];
         msr_view[6] = mcr_q[MCR_BANK];
         msr_view[5] = mcr_q[MCR_DTR];
         msr_view[4] = mcr_q[MCR_RTS];
      end
   end

   umr_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .rd(reg_rd), .sel(sel), .efr(efr_q), .mcr(mcr_q), .msr(msr_view),
      .tcr(tcr_q), .spr(spr_q), .tlr(tlr_q), .rdata(reg_rdata)
   );

   assign mcr_q_o   = mcr_q;
   assign tcr_o     = tcr_q;
   assign tlr_o     = tlr_q;
   assign enh_en_o  = efr_q[ENH_BIT];
   assign loop_en_o = loop_on;
   assign xon_any_o = mcr_q[MCR_XON];
   assign ir_en_o   = mcr_q[MCR_IR];
   assign lb_ri_o   = loop_on && mcr_q[MCR_BANK];
   assign op2_o     = loop_on ? !mcr_q[MCR_OP2] : 1'b1;
endmodule

// File: rtl/umr_checker.sv
module umr_checker #(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter int OFF_MCR  = 4,
   parameter int OFF_BNKA = 6,
   parameter int OFF_BNKB = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] reg_offset,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [DATA_W-1:0] mcr_q_o,
   input logic [DATA_W-1:0] tcr_o,
   input logic [DATA_W-1:0] tlr_o,
   input logic              enh_en_o,
   input logic              loop_en_o,
   input logic              lb_ri_o,
   input logic              op2_o
);
   logic alt;
   assign alt = enh_en_o && mcr_q_o[2];

   p_tcr_write_r1: assert property (@(posedge clk) disable iff (rst)
      reg_wr && reg_offset == ADDR_W'(OFF_BNKA) && alt |=> tcr_o == $past(reg_wdata));

   p_tlr_read_r2: assert property (@(posedge clk) disable iff (rst)
      reg_rd && reg_offset == ADDR_W'(OFF_BNKB) && alt |-> reg_rdata == tlr_o);

   p_guard_hold_r3: assert property (@(posedge clk) disable iff (rst)
      reg_wr && reg_offset == ADDR_W'(OFF_MCR) && !enh_en_o |=> mcr_q_o[6:5] == $past(mcr_q_o[6:5]));

   p_msr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
      reg_wr && reg_offset == ADDR_W'(OFF_BNKA) && !alt |=> $stable(tcr_o) && $stable(tlr_o) && $stable(mcr_q_o));

   p_ri_source_r6: assert property (@(posedge clk) disable iff (rst)
      lb_ri_o |-> loop_en_o && mcr_q_o[2]);

   p_op2_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !loop_en_o |-> op2_o);

   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> mcr_q_o == '0 && tcr_o == '0 && tlr_o == '0 && !enh_en_o);

   p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
      !reg_rd |-> reg_rdata == '0);
endmodule

bind uart_modem_regs umr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_MCR(OFF_MCR),
   .OFF_BNKA(OFF_BNKA), .OFF_BNKB(OFF_BNKB)
) u_chk (.*);

// File: tb/tb_uart_modem_regs.sv
module tb_uart_modem_regs;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] reg_offset = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0, enh_sel = 1'b0;
   logic [7:0] reg_wdata = '0, modem_stat_in = '0;
   logic [7:0] reg_rdata, mcr_q_o, tcr_o, tlr_o;
   logic       enh_en_o, loop_en_o, xon_any_o, ir_en_o, lb_ri_o, op2_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   logic [7:0] m_efr = '0, m_mcr = '0, m_tcr = '0, m_spr = '0, m_tlr = '0;

   uart_modem_regs dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic m_alt();
      return m_efr[4] && m_mcr[2];
   endfunction

   function automatic logic [7:0] m_status(input logic [7:0] st);
      logic [7:0] v = st;
      if (m_mcr[4]) v[7:4] = {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]};
      return v;
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] off, input logic sel, input logic [7:0] st);
      case (off)
         3'd2:    return sel ? m_efr : 8'h00;
         3'd4:    return m_mcr;
         3'd6:    return m_alt() ? m_tcr : m_status(st);
         3'd7:    return m_alt() ? m_tlr : m_spr;
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_write(input logic [2:0] off, input logic sel, input logic [7:0] d);
      case (off)
         3'd2: if (sel) m_efr = d;
         3'd4: m_mcr = m_efr[4] ? d : {d[7], m_mcr[6:5], d[4:0]};
         3'd6: if (m_alt()) m_tcr = d;
         3'd7: if (m_alt()) m_tlr = d; else m_spr = d;
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_outputs();
      chk("R10 mcr", mcr_q_o, m_mcr);
      chk("R1 tcr", tcr_o, m_tcr);
      chk("R2 tlr", tlr_o, m_tlr);
      chk("R10 enh", {7'd0, enh_en_o}, {7'd0, m_efr[4]});
      chk("R10 mode bits", {5'd0, ir_en_o, xon_any_o, loop_en_o}, {5'd0, m_mcr[6], m_mcr[5], m_mcr[4]});
      chk("R6 ri", {7'd0, lb_ri_o}, {7'd0, m_mcr[4] & m_mcr[2]});
      chk("R7 op2", {7'd0, op2_o}, {7'd0, m_mcr[4] ? ~m_mcr[3] : 1'b1});
   endtask

   task automatic do_wr(input logic [2:0] off, input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_offset = off; enh_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; enh_sel = 1'b0;
      m_write(off, sel, d);
      chk_outputs();
   endtask

   task automatic do_rd(input string req, input logic [2:0] off, input logic sel, input logic [7:0] st);
      @(negedge clk);
      reg_offset = off; enh_sel = sel; modem_stat_in = st; reg_rd = 1'b1;
      #(CLK_PERIOD/4);
      chk(req, reg_rdata, m_read(off, sel, st));
      reg_rd = 1'b0; enh_sel = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_1172);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8: reset state
      chk_outputs();
      chk("R8 rdata idle", reg_rdata, 8'h00);
      do_rd("R8 mcr after reset", 3'd4, 1'b0, 8'h00);
      // R9: offset 2 without select is ignored
      do_wr(3'd2, 1'b0, 8'hFF);
      do_rd("R9 efr unselected read", 3'd2, 1'b0, 8'h00);
      do_rd("R9 efr selected read", 3'd2, 1'b1, 8'h00);
      do_rd("R9 unowned offset", 3'd3, 1'b0, 8'h00);
      // R3: guarded bits with enhance off
      do_wr(3'd4, 1'b0, 8'hFF);
      chk("R3 guarded held", {6'd0, mcr_q_o[6:5]}, 8'h00);
      // R1/R2: bit 2 set but enhance off -> status/scratch
      do_wr(3'd6, 1'b0, 8'hA5);
      do_rd("R4 status read", 3'd6, 1'b0, 8'h3C);
      do_wr(3'd7, 1'b0, 8'h5A);
      do_rd("R2 scratch read", 3'd7, 1'b0, 8'h00);
      // R5: loopback substitution (mcr = 8'h9F currently)
      do_rd("R5 loop status", 3'd6, 1'b0, 8'h0F);
      // enable enhanced
      do_wr(3'd2, 1'b1, 8'h10);
      do_wr(3'd4, 1'b0, 8'h64);
      chk("R3 guarded written", {6'd0, mcr_q_o[6:5]}, 8'h03);
      do_wr(3'd6, 1'b0, 8'hC3);
      do_rd("R1 tcr read", 3'd6, 1'b0, 8'hFF);
      do_wr(3'd7, 1'b0, 8'h77);
      do_rd("R2 tlr read", 3'd7, 1'b0, 8'h00);
      // R4: leave bank, status write ignored
      do_wr(3'd4, 1'b0, 8'h18);
      do_wr(3'd6, 1'b0, 8'hEE);
      do_rd("R4 status after write", 3'd6, 1'b0, 8'h81);
      do_rd("R2 scratch kept", 3'd7, 1'b0, 8'h00);
      // R9: no strobe -> zero
      @(negedge clk);
      reg_offset = 3'd4; #(CLK_PERIOD/4);
      chk("R9 no read strobe", reg_rdata, 8'h00);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] off;
         logic [7:0] d;
         logic       s;
         int         r;
         r = $urandom_range(0, 9);
         off = (r < 2) ? 3'd2 : (r < 5) ? 3'd4 : (r < 7) ? 3'd6 : (r < 9) ? 3'd7 : 3'($urandom_range(0, 7));
         d = 8'($urandom);
         s = 1'($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 1) == 1) do_wr(off, s, d);
         else do_rd("R1 R2 R5 random read", off, s, d);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule